// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the address seen by the core of a synchronous burst memory. When either of two start strobes is high on a clock edge, it captures the external address. One start strobe comes from the processor side and the other from the memory controller side. It also records which burst order is selected at that moment. On each later edge where the advance input is high, it steps a two-bit beat count. The low two address bits are then recomputed from the captured base and the beat count, in either linear or interleaved order. The upper bits stay as captured.

The burst is optional. A host that drives a start strobe on every cycle gets a new address from the external bus on every cycle, with no lost cycle. A four-beat burst wraps back to its first beat after the fourth step. The order select is active high for linear order. Tying it low, which is its natural default, gives interleaved order.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives `addr_out` to all zeros from the edge after reset is sampled. It also clears the beat count.
- R2: A high level on `cpu_strobe` or on `ctl_strobe` at a clock edge captures `ext_addr`, and `addr_out` equals that address after the edge.
- R3: A start strobe takes precedence over `advance` in the same cycle. Both strobes high together also load `ext_addr`.
- R4: With both strobes and `advance` low, `addr_out` keeps its value whatever `ext_addr` and `order_linear` do.
- R5: While advancing, bits above bit 1 of `addr_out` stay equal to the captured base address.
- R6: In linear order (`order_linear` = 1 at load), after n advances the low two bits equal (base low bits + n) mod 4.
- R7: In interleaved order (`order_linear` = 0 at load), after n advances the low two bits equal base low bits XOR (n mod 4).
- R8: The order is captured at load. A change on `order_linear` during a burst has no effect until the next load.
- R9: The fifth beat (four advances) returns the low bits to the base value, and counting continues from there.
- R10: A start strobe on every consecutive cycle loads a new address on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address bus |
| cpu_strobe | input | 1 | Processor-side burst start |
| ctl_strobe | input | 1 | Controller-side burst start |
| advance | input | 1 | Step to the next beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_out | output | ADDR_W | Address presented to the memory core |

## Verification
The bench sweeps every starting low-bit value in both orders and through both strobes. Each burst runs five advances, so the wrap is seen as well as all four beats. Linear and interleaved order give different sequences for every odd base, so the sweep separates the two orders. During each burst the bench drives the opposite order level and a garbage external address, which tells a captured order apart from a live one. Idle gaps, a strobe together with advance, both strobes at once, back-to-back loads and a reset in the middle of a burst cover hold, precedence and full-rate loading.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } order_e;

    typedef struct packed {
        beat_t  lo;
        order_e ord;
    } low_ctx_t;

    // Low address bits for a given beat of a burst.
    function automatic beat_t map_low(input beat_t base_lo, input beat_t beat, input order_e ord);
        beat_t res;
        if (ord == ORD_LINEAR) res = base_lo + beat;
        else                   res = base_lo ^ beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter import burst_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    output beat_t beat
);
    always_ff @(posedge clk) begin
        if (rst)       beat <= '0;
        else if (load) beat <= '0;
        else if (step) beat <= beat + beat_t'(1);
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg import burst_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                order_in,
    output logic [ADDR_W-3:0]   upper_q,
    output low_ctx_t            ctx_q
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            ctx_q   <= '{lo: '0, ord: ORD_INTERLEAVED};
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1 -: UPPER_W];
            ctx_q   <= '{lo: addr_in[BEAT_W-1:0], ord: order_e'(order_in)};
        end
    end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map import burst_pkg::*; (
    input  low_ctx_t ctx,
    input  beat_t    beat,
    output beat_t    low
);
    always_comb low = map_low(ctx.lo, beat, ctx.ord);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen import burst_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              advance,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic                load;
    logic [UPPER_W-1:0]  upper_q;
    low_ctx_t            ctx_q;
    beat_t               beat_q;
    beat_t               low_now;

    // Either strobe starts a burst; a start always beats an advance.
    always_comb load = cpu_strobe | ctl_strobe;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .addr_in  (ext_addr),
        .order_in (order_linear),
        .upper_q  (upper_q),
        .ctx_q    (ctx_q)
    );

    burst_beat_counter u_beat (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (advance),
        .beat (beat_q)
    );

    burst_low_map u_map (
        .ctx  (ctx_q),
        .beat (beat_q),
        .low  (low_now)
    );

    always_comb addr_out = {upper_q, low_now};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              cpu_strobe,
    input logic              ctl_strobe,
    input logic              advance,
    input logic [ADDR_W-1:0] addr_out
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> addr_out == '0);

    // R2 and R3: any strobe loads, even with advance high
    a_r2_strobe_loads: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe || ctl_strobe) |=> addr_out == $past(ext_addr));

    // R4
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe && !advance) |=> $stable(addr_out));

    // R5
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe && advance) |=>
            addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    // R6 and R7: every step moves the low bits in either order
    a_r6_step_moves: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe && advance) |=>
            addr_out[1:0] != $past(addr_out[1:0]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst, cpu, ctl, adv, ordl;
    logic [AW-1:0] ea;
    logic [AW-1:0] out;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk(clk), .rst(rst), .ext_addr(ea), .cpu_strobe(cpu),
        .ctl_strobe(ctl), .advance(adv), .order_linear(ordl), .addr_out(out)
    );

    task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic t, input logic a,
                       input logic o, input logic [AW-1:0] addr);
        cpu = c; ctl = t; adv = a; ordl = o; ea = addr;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] model(input logic [AW-1:0] base, input int n, input bit lin);
        int lo;
        if (lin) lo = (int'(base[1:0]) + n) % 4;
        else     lo = int'(base[1:0]) ^ (n % 4);
        return {base[AW-1:2], 2'(lo)};
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] base, prev;
        rst = 1'b1; cpu = 0; ctl = 0; adv = 0; ordl = 0; ea = '1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 reset", out, '0);
        rst = 1'b0;

        // Sweep: order x strobe x base low bits, five advances each.
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    base = AW'((lo * 293 + o * 1031 + s * 77 + 5) << 2) | AW'(lo);
                    cyc(s == 0, s == 1, 1'b0, o[0], base);
                    chk("R2 load", out, base);
                    for (int k = 1; k <= 5; k++) begin
                        // opposite order level and garbage address: R8
                        cyc(1'b0, 1'b0, 1'b1, ~o[0], ~base);
                        chk(o == 1 ? "R6 linear/R8" : "R7 interleaved/R8",
                            out, model(base, k, o == 1));
                        chk("R5 upper", {out[AW-1:2], 2'b00}, {base[AW-1:2], 2'b00});
                        if (k == 4) chk("R9 wrap", out, base);
                    end
                    prev = out;
                    cyc(1'b0, 1'b0, 1'b0, ~o[0], base ^ 12'h5A5);
                    chk("R4 hold", out, prev);
                    cyc(1'b0, 1'b0, 1'b1, o[0], '0);
                    chk("R4 resume", out, model(base, 6, o == 1));
                end
            end
        end

        // R3: strobe with advance, and both strobes together
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 12'h3C1);
        chk("R3 load over advance", out, 12'h3C1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'hA72);
        chk("R3 both strobes", out, 12'hA72);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        chk("R3 beat restarted", out, 12'hA73);

        // R10: loads on consecutive cycles
        for (int i = 0; i < 10; i++) begin
            base = AW'(i * 409 + 13);
            cyc(i[0], ~i[0], 1'b0, 1'b0, base);
            chk("R10 full rate", out, base);
        end

        // R1: reset mid-burst
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFE);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        rst = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        chk("R1 mid-burst reset", out, '0);
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        chk("R1 beat cleared", out, 12'h001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule